// File: doc/BRIEF.md
# Time-Slot List Frame Sequencer

This block divides a serial audio frame into byte-wide time slots and decides what happens in each slot by reading a programmable slot list. A slot lasts eight bit ticks. The bit tick is a one-cycle enable supplied by the bit-clock logic. The list holds up to 32 entries. A pass through the list is one super frame of up to 256 bits, and then the list starts again from the top.

Each entry sets the following for its slot:
- which serial data line is addressed, and so which word-select output pulses;
- whether the byte is received into the input queue;
- whether a byte is loaded from the output queue for transmission;
- whether the received byte is captured for loopback.

A looped-back byte is stored against a target slot. When that slot next comes up, the stored byte replaces the output-queue byte. Because several devices can each own a different slot, they can share one data line. The block only sequences at byte level. Shift registers, bus mastering and addresses belong to the neighbouring logic.

Top module: `tsl_frame_seq`

## Requirements
- R1: While `run` is high, the slot index advances by one after every eighth `bit_tick`. It holds its value in cycles without a tick.
- R2: On the eighth tick of a slot whose entry has the end-of-frame bit (bit 11) set, the slot index returns to 0. It also returns to 0 after slot 31.
- R3: On the first tick of a slot, `ws` is one-hot at the position given by entry bits [10:8]. `ws` is zero at every other time, and also when the line code is 5 or higher.
- R4: On the first tick of a slot whose transmit bit (bit 6) is set, `tx_load` and `outq_pop` are high and `tx_byte` equals `outq_data`, unless R6 applies.
- R5: On the eighth tick of a slot whose receive bit (bit 7) is set, `inq_push` is high and `inq_data` equals `rx_byte`.
- R6: On the eighth tick of a slot whose loopback bit (bit 5) is set, `rx_byte` is stored for the slot in bits [4:0]. The target may be the same slot. The next time the target slot starts with transmit set, `tx_byte` is the stored byte, `outq_pop` stays low, and the stored byte is used up.
- R7: List writes (`cfg_we`, `cfg_addr`, `cfg_data`) take effect only while `run` is low. A write while running is ignored.
- R8: While `run` is low, the slot index and bit position are held at 0 and stored loopback bytes are discarded. A start therefore begins at slot 0.
- R9: After reset, all list entries are zero, the slot index is 0 and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Sequencer enable; low stops and rewinds |
| bit_tick | input | 1 | One-cycle strobe per serial bit |
| cfg_we | input | 1 | Slot-list write strobe |
| cfg_addr | input | 5 | Slot-list entry index |
| cfg_data | input | 12 | Entry: [11] end, [10:8] line, [7] rx, [6] tx, [5] loop, [4:0] target |
| rx_byte | input | 8 | Byte assembled by the deserialiser |
| outq_data | input | 8 | Head byte of the output queue |
| slot_idx | output | 5 | Current slot index |
| ws | output | 5 | Per-line word-select strobe |
| tx_load | output | 1 | Load `tx_byte` into the serialiser |
| tx_byte | output | 8 | Byte to transmit |
| outq_pop | output | 1 | Output-queue pop |
| inq_push | output | 1 | Input-queue push |
| inq_data | output | 8 | Byte pushed into the input queue |

## Verification
All strobes (`ws`, `tx_load`, `outq_pop`, `inq_push`) and their data are combinational. They are due in the same cycle as the `bit_tick` that opens or closes a slot. `slot_idx`, list writes and loopback storage become visible one clock after the tick or write that causes them. The bench drives inputs at the falling edge, compares every output one nanosecond later against a behavioural model, and then steps the model. Each expected value is therefore taken in exactly the cycle the design owes it. Ignored writes and discarded loopback bytes show up later at `ws` and `tx_byte`.

// File: rtl/tsl_pkg.sv
package tsl_pkg;
  localparam int NUM_SLOTS = 32;
  localparam int IDX_W     = $clog2(NUM_SLOTS);
  localparam int BYTE_W    = 8;
  localparam int BITS_PER_SLOT = 8;

  typedef struct packed {
    logic             eof;
    logic [2:0]       line;
    logic             rx_en;
    logic             tx_en;
    logic             lb_en;
    logic [IDX_W-1:0] lb_tgt;
  } slot_entry_t;

  localparam int ENTRY_W = $bits(slot_entry_t);
endpackage

// File: rtl/tsl_slot_list.sv
module tsl_slot_list
  import tsl_pkg::*;
#(
  parameter int SLOTS = NUM_SLOTS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_addr,
  input  slot_entry_t      wr_data,
  input  logic [IDX_W-1:0] rd_addr,
  output slot_entry_t      rd_data
);
  slot_entry_t mem_q [SLOTS];
  logic        wr_ok;

  assign wr_ok   = wr_en & ~run;
  assign rd_data = mem_q[rd_addr];

  for (genvar g = 0; g < SLOTS; g++) begin : g_entry
    logic sel;
    assign sel = wr_ok & (wr_addr == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mem_q[g] <= '0;
      else if (sel) mem_q[g] <= wr_data;
    end
    AST_LIST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      run |=> $stable(mem_q[g])); // R7
  end
endmodule

// File: rtl/tsl_slot_timer.sv
module tsl_slot_timer
  import tsl_pkg::*;
#(
  parameter int SLOTS = NUM_SLOTS,
  parameter int BITS  = BITS_PER_SLOT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             bit_tick,
  input  logic             end_mark,
  output logic [IDX_W-1:0] slot,
  output logic             first_bit,
  output logic             last_bit
);
  localparam int BC_W = $clog2(BITS);

  logic [BC_W-1:0]  bcnt_q, bcnt_d;
  logic [IDX_W-1:0] slot_q, slot_d;
  logic             wrap;

  assign first_bit = run & bit_tick & (bcnt_q == '0);
  assign last_bit  = run & bit_tick & (bcnt_q == BC_W'(BITS-1));
  assign wrap      = end_mark | (slot_q == IDX_W'(SLOTS-1));
  assign slot      = slot_q;

  always_comb begin
    bcnt_d = bcnt_q;
    slot_d = slot_q;
    if (!run) begin
      bcnt_d = '0;
      slot_d = '0;
    end else if (bit_tick) begin
      if (last_bit) begin
        bcnt_d = '0;
        slot_d = wrap ? '0 : slot_q + 1'b1;
      end else begin
        bcnt_d = bcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt_q <= '0;
      slot_q <= '0;
    end else begin
      bcnt_q <= bcnt_d;
      slot_q <= slot_d;
    end
  end

  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (last_bit && !wrap) |=> slot_q == $past(slot_q) + 1'b1); // R1
  AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !bit_tick) |=> $stable(slot_q)); // R1
  AST_STOP_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> slot_q == '0); // R8
endmodule

// File: rtl/tsl_loop_buffer.sv
module tsl_loop_buffer
  import tsl_pkg::*;
#(
  parameter int SLOTS = NUM_SLOTS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              store,
  input  logic [IDX_W-1:0]  store_slot,
  input  logic [BYTE_W-1:0] store_byte,
  input  logic              take,
  input  logic [IDX_W-1:0]  take_slot,
  output logic              hit,
  output logic [BYTE_W-1:0] hit_byte
);
  logic [BYTE_W-1:0] byte_q [SLOTS];
  logic [SLOTS-1:0]  vld_q, vld_d;

  assign hit      = vld_q[take_slot];
  assign hit_byte = byte_q[take_slot];

  always_comb begin
    vld_d = vld_q;
    if (!run) vld_d = '0;
    else begin
      if (take && hit) vld_d[take_slot]  = 1'b0;
      if (store)       vld_d[store_slot] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_byte
    logic wen;
    assign wen = store & (store_slot == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   byte_q[g] <= '0;
      else if (wen) byte_q[g] <= store_byte;
    end
  end

  AST_LOOP_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
    (take && hit && !store) |=> !vld_q[$past(take_slot)]); // R6
endmodule

// File: rtl/tsl_frame_seq.sv
module tsl_frame_seq
  import tsl_pkg::*;
#(
  parameter int LINES = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              bit_tick,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_addr,
  input  logic [ENTRY_W-1:0] cfg_data,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic [BYTE_W-1:0] outq_data,
  output logic [IDX_W-1:0]  slot_idx,
  output logic [LINES-1:0]  ws,
  output logic              tx_load,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              outq_pop,
  output logic              inq_push,
  output logic [BYTE_W-1:0] inq_data
);
  slot_entry_t       ent;
  logic              first_bit, last_bit, lb_hit;
  logic [BYTE_W-1:0] lb_byte;

  tsl_slot_list #(.SLOTS(NUM_SLOTS)) u_list (
    .clk(clk), .rst_n(rst_n), .run(run),
    .wr_en(cfg_we), .wr_addr(cfg_addr), .wr_data(slot_entry_t'(cfg_data)),
    .rd_addr(slot_idx), .rd_data(ent)
  );

  tsl_slot_timer #(.SLOTS(NUM_SLOTS), .BITS(BITS_PER_SLOT)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .bit_tick(bit_tick),
    .end_mark(ent.eof), .slot(slot_idx),
    .first_bit(first_bit), .last_bit(last_bit)
  );

  tsl_loop_buffer #(.SLOTS(NUM_SLOTS)) u_loop (
    .clk(clk), .rst_n(rst_n), .run(run),
    .store(last_bit & ent.lb_en), .store_slot(ent.lb_tgt), .store_byte(rx_byte),
    .take(tx_load), .take_slot(slot_idx),
    .hit(lb_hit), .hit_byte(lb_byte)
  );

  for (genvar l = 0; l < LINES; l++) begin : g_ws
    assign ws[l] = first_bit & (ent.line == 3'(l));
  end

  assign tx_load  = first_bit & ent.tx_en;
  assign outq_pop = tx_load & ~lb_hit;
  assign tx_byte  = lb_hit ? lb_byte : outq_data;
  assign inq_push = last_bit & ent.rx_en;
  assign inq_data = rx_byte;

  AST_WS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ws)); // R3
  AST_WS_SLOT_START: assert property (@(posedge clk) disable iff (!rst_n)
    (ws != '0) |=> !(ws != '0)); // R3
  AST_PUSH_NOT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    inq_push |-> !tx_load); // R5
endmodule

// File: tb/tb_tsl_frame_seq.sv
`timescale 1ns/1ps
module tb_tsl_frame_seq;
  logic clk = 0, rst_n = 0, run = 0, bit_tick = 0, cfg_we = 0;
  logic [4:0] cfg_addr = 0;
  logic [11:0] cfg_data = 0;
  logic [7:0] rx_byte = 0, outq_data = 0;
  logic [4:0] slot_idx, ws;
  logic tx_load, outq_pop, inq_push;
  logic [7:0] tx_byte, inq_data;

  tsl_frame_seq dut (.*);

  always #2.5 clk = ~clk;

  int errors = 0, checks = 0, cyc = 0;
  string phase = "";
  bit finished = 0;

  int lst [32];
  int lbd [32];
  bit lbv [32];
  int m_slot = 0, m_bit = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s [%s] cyc=%0d actual=%0h expected=%0h", req, phase, cyc, act, exp);
    end
  endtask

  task automatic step(input bit r, input bit t, input bit we, input int wa, input int wd);
    int e, line, ews, eload, ehit, epush;
    bit first, last;
    @(negedge clk);
    run = r; bit_tick = t; cfg_we = we; cfg_addr = wa[4:0]; cfg_data = wd[11:0];
    rx_byte = 8'((cyc * 37 + 5) & 255); outq_data = 8'((cyc * 11 + 90) & 255);
    #1;
    first = r && t && m_bit == 0;
    last  = r && t && m_bit == 7;
    e = lst[m_slot]; line = (e >> 8) & 7;
    ews = (first && line < 5) ? (1 << line) : 0;
    eload = first && e[6]; ehit = eload && lbv[m_slot];
    epush = last && e[7];
    chk("R1 R2 R8 slot_idx", slot_idx, m_slot);
    chk("R3 ws", ws, ews);
    chk("R4 tx_load", tx_load, eload);
    chk("R4 R6 outq_pop", outq_pop, eload && !ehit);
    if (eload) chk("R4 R6 tx_byte", tx_byte, ehit ? lbd[m_slot] : outq_data);
    chk("R5 inq_push", inq_push, epush);
    if (epush) chk("R5 inq_data", inq_data, rx_byte);
    if (!r) begin
      m_slot = 0; m_bit = 0;
      for (int i = 0; i < 32; i++) lbv[i] = 0;
      if (we) lst[wa] = wd;   // R7: accepted only when stopped
    end else if (t) begin
      if (ehit) lbv[m_slot] = 0;
      if (last) begin
        if (e[5]) begin lbd[e & 31] = rx_byte; lbv[e & 31] = 1; end
        m_slot = (e[11] || m_slot == 31) ? 0 : m_slot + 1;
        m_bit = 0;
      end else m_bit++;
    end
    cyc++;
  endtask

  function automatic int ent(int eof, int line, int rx, int tx, int lb, int tgt);
    return (eof << 11) | (line << 8) | (rx << 7) | (tx << 6) | (lb << 5) | tgt;
  endfunction

  initial begin
    for (int i = 0; i < 32; i++) begin lst[i] = 0; lbd[i] = 0; lbv[i] = 0; end
    // R9: reset state
    phase = "reset R9";
    #1;
    chk("R9 slot_idx", slot_idx, 0);
    chk("R9 ws", ws, 0);
    chk("R9 strobes", {tx_load, outq_pop, inq_push}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < 3; i++) step(0, 1, 0, 0, 0);

    phase = "short frame";
    step(0, 0, 1, 0, ent(0, 0, 0, 1, 0, 0));
    step(0, 0, 1, 1, ent(0, 1, 1, 0, 1, 3));
    step(0, 0, 1, 2, ent(0, 6, 1, 1, 0, 0));
    step(0, 0, 1, 3, ent(1, 2, 0, 1, 0, 0));
    for (int i = 0; i < 200; i++) step(1, i % 2, 0, 0, 0);

    // R7: writes while running are ignored
    phase = "write while running R7";
    for (int i = 0; i < 100; i++) step(1, i % 3 == 0, i < 4, i, ent(1, 4, 1, 1, 1, 0));

    // R8: stop mid-frame, loopback bytes discarded, restart from slot 0
    phase = "stop restart R8";
    for (int i = 0; i < 5; i++) step(0, 1, 0, 0, 0);
    for (int i = 0; i < 150; i++) step(1, 1, 0, 0, 0);

    phase = "full list, same-slot loopback R2 R6";
    for (int i = 0; i < 32; i++)
      step(0, 0, 1, i, ent(0, i % 8, i % 2, (i % 3) != 0, i % 4 == 1, (i % 4 == 1) ? (i + 2 * (i % 8 == 1)) % 32 : 0));
    for (int i = 0; i < 900; i++) step(1, 1, 0, 0, 0);
    for (int i = 0; i < 600; i++) step(1, (i % 5) != 2, 0, 0, 0);
    phase = "stop";
    for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule